// File: doc/BRIEF.md
# CCD line pixel sequencer with black clamp

This block sits between a linear CCD sensor's ADC and the image pipeline. A line-start strobe marks the transfer gate of a new line. After it, every pixel-clock strobe stands for one sensor output sample. The sensor's output settles well after the clock edge, so the block delays each strobe by a fixed number of system clocks before it captures the ADC word. Each captured sample is tagged by its position in the line.

The line has a fixed layout. Leading dummies come first. Optically shielded reference pixels follow, then a short run of dummies, then the effective pixels, and trailing dummies close the line. The block sums the shielded pixels and divides the sum by their count through a fixed-point reciprocal multiply, which gives the black level. Each effective pixel then leaves the block with the black level subtracted, clipped at zero.

The output is a valid-qualified stream. Start-of-line and end-of-line markers sit on the first and last effective pixels. A line-start strobe that arrives before the line is complete restarts the count and pulses an overrun flag.

Top module: `ccd_line_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid`, `out_sol`, `out_eol` and `overrun` are low.
- R2: The sample index after a line start is 0-based. `out_valid` rises only for samples whose index lies in [LEAD_DUMMY+BLACK_COUNT+GAP_DUMMY, +ACTIVE_COUNT). A complete line of LEAD_DUMMY+BLACK_COUNT+GAP_DUMMY+ACTIVE_COUNT+TAIL_DUMMY samples gives exactly ACTIVE_COUNT outputs.
- R3: The black level of a line is floor(sum of samples with index in [LEAD_DUMMY, LEAD_DUMMY+BLACK_COUNT) / BLACK_COUNT). Dummy samples do not contribute. The sum restarts with every line, and the level is ready before the first effective pixel when GAP_DUMMY is at least 1.
- R4: Each output pixel equals the captured sample minus the black level of its line, or 0 when the sample is not above the black level.
- R5: `out_sol` is high only together with the first effective pixel of a line, and `out_eol` only together with the ACTIVE_COUNT-th.
- R6: The ADC word is captured CAPTURE_DELAY clocks after the clock in which `pix_stb` is sampled high. The corrected pixel appears one clock after the capture, and the ADC value at any other time has no effect.
- R7: A `line_start` that arrives while a line is still incomplete restarts the index at 0 and makes `overrun` high for exactly the following cycle. A `line_start` after a complete line, or after reset, leaves `overrun` low.
- R8: Strobes after a complete line and before the next `line_start` produce no output. A capture that coincides with `line_start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-cycle pulse at the transfer gate of a new line |
| pix_stb | input | 1 | One-cycle pulse per sensor pixel clock |
| adc_data | input | DATA_W | ADC sample, valid at the delayed capture point |
| pix_out | output | DATA_W | Black-corrected effective pixel |
| out_valid | output | 1 | `pix_out` holds an effective pixel |
| out_sol | output | 1 | First effective pixel of the line |
| out_eol | output | 1 | Last effective pixel of the line |
| overrun | output | 1 | One-cycle pulse: line restarted before completion |

## Verification
On every cycle, the assertions check the following:
- The markers never appear without a valid pixel.
- The end marker falls exactly on the ACTIVE_COUNT-th output since the line start.
- No line gives more than ACTIVE_COUNT outputs.
- The overrun pulse only follows a line start.
- The outputs are quiet after reset.

Some behaviour can only be shown by the bench's scenarios:
- The black arithmetic, checked against an exact integer division.
- Saturation at zero, checked with effective pixels below the black level.
- The capture delay, checked by presenting a wrong ADC word until the exact capture clock.
- Aborted lines and strobes outside a line being ignored.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
   typedef enum logic [1:0] {
      ZONE_DUMMY  = 2'd0,
      ZONE_BLACK  = 2'd1,
      ZONE_ACTIVE = 2'd2
   } zone_e;
endpackage

// File: rtl/ccdseq_delay.sv
module ccdseq_delay #(
   parameter int DEPTH = 58
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign dout = din;
      end else if (DEPTH == 1) begin : g_one
         logic stage;
         always_ff @(posedge clk) begin
            if (rst) stage <= 1'b0;
            else     stage <= din;
         end
         assign dout = stage;
      end else begin : g_chain
         logic [DEPTH-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[DEPTH-2:0], din};
         end
         assign dout = chain[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/ccdseq_counter.sv
module ccdseq_counter
   import ccdseq_pkg::*;
#(
   parameter int LEAD_DUMMY   = 24,
   parameter int BLACK_COUNT  = 30,
   parameter int GAP_DUMMY    = 2,
   parameter int ACTIVE_COUNT = 3000,
   parameter int TAIL_DUMMY   = 10
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  line_start,
   input  logic  cap,
   output logic  take,
   output zone_e zone,
   output logic  first_act,
   output logic  last_act,
   output logic  last_black,
   output logic  overrun
);
   localparam int LINE_LEN  = LEAD_DUMMY + BLACK_COUNT + GAP_DUMMY + ACTIVE_COUNT + TAIL_DUMMY;
   localparam int IDX_W     = $clog2(LINE_LEN + 1);
   localparam int ACT_FIRST = LEAD_DUMMY + BLACK_COUNT + GAP_DUMMY;
   localparam logic [IDX_W-1:0] BLK_LO = IDX_W'(LEAD_DUMMY);
   localparam logic [IDX_W-1:0] BLK_HI = IDX_W'(LEAD_DUMMY + BLACK_COUNT - 1);
   localparam logic [IDX_W-1:0] ACT_LO = IDX_W'(ACT_FIRST);
   localparam logic [IDX_W-1:0] ACT_HI = IDX_W'(ACT_FIRST + ACTIVE_COUNT - 1);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(LINE_LEN - 1);

   logic [IDX_W-1:0] idx;
   logic             busy;

   assign take = cap && busy && !line_start;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx     <= '0;
         busy    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         overrun <= line_start && busy;
         if (line_start) begin
            idx  <= '0;
            busy <= 1'b1;
         end else if (take) begin
            if (idx == IDX_END) begin
               idx  <= '0;
               busy <= 1'b0;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (idx >= BLK_LO && idx <= BLK_HI)      zone = ZONE_BLACK;
      else if (idx >= ACT_LO && idx <= ACT_HI) zone = ZONE_ACTIVE;
      else                                     zone = ZONE_DUMMY;
   end

   assign first_act  = (idx == ACT_LO);
   assign last_act   = (idx == ACT_HI);
   assign last_black = (idx == BLK_HI);
endmodule

// File: rtl/ccdseq_black.sv
module ccdseq_black
   import ccdseq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int BLACK_COUNT = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              take,
   input  zone_e             zone,
   input  logic              last_black,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] black
);
   localparam int SUM_W = DATA_W + $clog2(BLACK_COUNT + 1);
   localparam int SH    = $clog2(BLACK_COUNT);
   localparam int FRAC  = SUM_W + SH;
   localparam logic [63:0] RECIP = ((64'd1 << FRAC) + 64'(BLACK_COUNT) - 64'd1) / 64'(BLACK_COUNT);

   logic [SUM_W-1:0]  acc;
   logic [SUM_W-1:0]  sum_q;
   logic              sum_rdy;
   logic [DATA_W-1:0] avg;
   logic [SUM_W-1:0]  acc_next;

   assign acc_next = acc + SUM_W'(data);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc     <= '0;
         sum_q   <= '0;
         sum_rdy <= 1'b0;
         black   <= '0;
      end else begin
         sum_rdy <= take && zone == ZONE_BLACK && last_black;
         if (clear) begin
            acc <= '0;
         end else if (take && zone == ZONE_BLACK) begin
            acc <= last_black ? '0 : acc_next;
            if (last_black) sum_q <= acc_next;
         end
         if (sum_rdy) black <= avg;
      end
   end

   generate
      if ((BLACK_COUNT & (BLACK_COUNT - 1)) == 0) begin : g_shift
         assign avg = DATA_W'(sum_q >> SH);
      end else begin : g_recip
         logic [63:0] prod;
         assign prod = 64'(sum_q) * RECIP;
         assign avg  = DATA_W'(prod >> FRAC);
      end
   endgenerate
endmodule

// File: rtl/ccdseq_correct.sv
module ccdseq_correct
   import ccdseq_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  zone_e             zone,
   input  logic              first_act,
   input  logic              last_act,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] black,
   output logic [DATA_W-1:0] pix_out,
   output logic              out_valid,
   output logic              out_sol,
   output logic              out_eol
);
   logic hit;
   assign hit = take && zone == ZONE_ACTIVE;

   always_ff @(posedge clk) begin
      if (rst) begin
         pix_out   <= '0;
         out_valid <= 1'b0;
         out_sol   <= 1'b0;
         out_eol   <= 1'b0;
      end else begin
         out_valid <= hit;
         out_sol   <= hit && first_act;
         out_eol   <= hit && last_act;
         if (hit) pix_out <= (data > black) ? data - black : '0;
      end
   end
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
   import ccdseq_pkg::*;
#(
   parameter int DATA_W        = 12,
   parameter int LEAD_DUMMY    = 24,
   parameter int BLACK_COUNT   = 30,
   parameter int GAP_DUMMY     = 2,
   parameter int ACTIVE_COUNT  = 3000,
   parameter int TAIL_DUMMY    = 10,
   parameter int CAPTURE_DELAY = 58
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_start,
   input  logic              pix_stb,
   input  logic [DATA_W-1:0] adc_data,
   output logic [DATA_W-1:0] pix_out,
   output logic              out_valid,
   output logic              out_sol,
   output logic              out_eol,
   output logic              overrun
);
   localparam int SUM_W = DATA_W + $clog2(BLACK_COUNT + 1);
   localparam int FRAC  = SUM_W + $clog2(BLACK_COUNT);

   generate
      if (GAP_DUMMY < 1) begin : g_bad_gap
         $error("GAP_DUMMY must be at least 1 so the black level is ready in time");
      end
      if (BLACK_COUNT < 1 || ACTIVE_COUNT < 1) begin : g_bad_count
         $error("BLACK_COUNT and ACTIVE_COUNT must be positive");
      end
      if (FRAC + SUM_W > 62) begin : g_bad_width
         $error("DATA_W too large for the reciprocal multiply");
      end
      if (CAPTURE_DELAY < 0) begin : g_bad_delay
         $error("CAPTURE_DELAY must not be negative");
      end
   endgenerate

   logic              cap;
   logic              take;
   zone_e             zone;
   logic              first_act;
   logic              last_act;
   logic              last_black;
   logic [DATA_W-1:0] black;

   ccdseq_delay #(.DEPTH(CAPTURE_DELAY)) u_delay (
      .clk(clk), .rst(rst), .din(pix_stb), .dout(cap)
   );

   ccdseq_counter #(
      .LEAD_DUMMY(LEAD_DUMMY), .BLACK_COUNT(BLACK_COUNT), .GAP_DUMMY(GAP_DUMMY),
      .ACTIVE_COUNT(ACTIVE_COUNT), .TAIL_DUMMY(TAIL_DUMMY)
   ) u_counter (
      .clk(clk), .rst(rst), .line_start(line_start), .cap(cap), .take(take),
      .zone(zone), .first_act(first_act), .last_act(last_act),
      .last_black(last_black), .overrun(overrun)
   );

   ccdseq_black #(.DATA_W(DATA_W), .BLACK_COUNT(BLACK_COUNT)) u_black (
      .clk(clk), .rst(rst), .clear(line_start), .take(take), .zone(zone),
      .last_black(last_black), .data(adc_data), .black(black)
   );

   ccdseq_correct #(.DATA_W(DATA_W)) u_correct (
      .clk(clk), .rst(rst), .take(take), .zone(zone), .first_act(first_act),
      .last_act(last_act), .data(adc_data), .black(black), .pix_out(pix_out),
      .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol)
   );
endmodule

// File: rtl/ccd_line_seq_chk.sv
module ccd_line_seq_chk #(
   parameter int ACTIVE_COUNT = 3000
) (
   input logic clk,
   input logic rst,
   input logic line_start,
   input logic out_valid,
   input logic out_sol,
   input logic out_eol,
   input logic overrun
);
   logic [31:0] seen;

   always_ff @(posedge clk) begin
      if (rst)             seen <= '0;
      else if (line_start) seen <= '0;
      else if (out_valid)  seen <= seen + 32'd1;
   end

   // R1: quiet outputs after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_sol && !out_eol && !overrun));

   // R2: never more effective pixels than the line holds
   a_r2_bounded_count: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (seen < 32'(ACTIVE_COUNT)));

   // R5: start marker on the first output of the line
   a_r5_sol_first: assert property (@(posedge clk) disable iff (rst)
      out_sol |-> (out_valid && seen == 32'd0));

   // R5: end marker on the last output of the line
   a_r5_eol_last: assert property (@(posedge clk) disable iff (rst)
      out_eol |-> (out_valid && seen == 32'(ACTIVE_COUNT - 1)));

   // R7: overrun only follows a line start
   a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
      overrun |-> $past(line_start));
endmodule

bind ccd_line_seq ccd_line_seq_chk #(.ACTIVE_COUNT(ACTIVE_COUNT)) u_chk (
   .clk(clk), .rst(rst), .line_start(line_start), .out_valid(out_valid),
   .out_sol(out_sol), .out_eol(out_eol), .overrun(overrun)
);

// File: tb/ccd_line_seq_tb.sv
`timescale 1ns/1ps
module ccd_line_seq_tb;
   localparam int DW     = 12;
   localparam int LEAD   = 24;
   localparam int NBLK   = 30;
   localparam int GAP    = 2;
   localparam int NACT   = 40;
   localparam int TAIL   = 10;
   localparam int DLY    = 5;
   localparam int PER    = 8;
   localparam int ACT0   = LEAD + NBLK + GAP;
   localparam int LINE_N = ACT0 + NACT + TAIL;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic line_start = 1'b0;
   logic pix_stb = 1'b0;
   logic [DW-1:0] adc_data = '0;
   logic [DW-1:0] pix_out;
   logic out_valid, out_sol, out_eol, overrun;

   typedef struct packed {
      logic [DW-1:0] pix;
      logic          sol;
      logic          eol;
   } exp_t;
   exp_t q[$];

   int checks = 0;
   int errors = 0;
   int n_out  = 0;

   always #2 clk = ~clk;

   ccd_line_seq #(
      .DATA_W(DW), .LEAD_DUMMY(LEAD), .BLACK_COUNT(NBLK), .GAP_DUMMY(GAP),
      .ACTIVE_COUNT(NACT), .TAIL_DUMMY(TAIL), .CAPTURE_DELAY(DLY)
   ) u_dut (
      .clk(clk), .rst(rst), .line_start(line_start), .pix_stb(pix_stb),
      .adc_data(adc_data), .pix_out(pix_out), .out_valid(out_valid),
      .out_sol(out_sol), .out_eol(out_eol), .overrun(overrun)
   );

   function automatic int base_of(int p);
      case (p)
         0: return 120;
         1: return 300;
         2: return 5;
         default: return 777;
      endcase
   endfunction

   function automatic logic [DW-1:0] val(int p, int k);
      int t;
      if (k >= LEAD && k < LEAD + NBLK) return DW'(base_of(p) + (k * 13 + p * 5) % 17);
      if (k >= ACT0 && k < ACT0 + NACT) begin
         t = k - ACT0;
         if (t % 5 == 0) return '0;
         if (t % 7 == 3) return '1;
         t = (t * 97 + p * 31) % 400 + base_of(p) - 100;
         return (t < 0) ? '0 : DW'(t);
      end
      return '1;
   endfunction

   // Monitor: pops expected pixels (R3 R4 R5 R6, unexpected output R2 R8)
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         n_out++;
         checks++;
         if (q.size() == 0) begin
            errors++;
            $display("FAIL R2 R8 unexpected pixel: got %0d, expected none", pix_out);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (pix_out !== e.pix) begin
               errors++;
               $display("FAIL R3 R4 R6 pixel: got %0d, expected %0d", pix_out, e.pix);
            end
            checks++;
            if (out_sol !== e.sol || out_eol !== e.eol) begin
               errors++;
               $display("FAIL R5 markers: got sol=%0b eol=%0b, expected sol=%0b eol=%0b",
                        out_sol, out_eol, e.sol, e.eol);
            end
         end
      end
   end

   // One pixel clock: a wrong word is shown until the capture clock (R6)
   task automatic send(input logic [DW-1:0] v);
      @(negedge clk);
      pix_stb  = 1'b1;
      adc_data = ~v;
      @(negedge clk);
      pix_stb = 1'b0;
      repeat (DLY - 1) @(negedge clk);
      adc_data = v;
      repeat (PER - DLY - 1) @(negedge clk);
   endtask

   task automatic run_line(input int p, input int n, input logic ov_exp);
      int sum;
      int blk;
      logic [DW-1:0] v;
      exp_t e;
      sum = 0;
      blk = 0;
      @(negedge clk);
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      n_out = 0;
      checks++;
      if (overrun !== ov_exp) begin
         errors++;
         $display("FAIL R7 overrun: got %0b, expected %0b", overrun, ov_exp);
      end
      for (int k = 0; k < n; k++) begin
         v = val(p, k);
         if (k >= LEAD && k < LEAD + NBLK) sum += int'(v);
         if (k == LEAD + NBLK - 1) blk = sum / NBLK;
         if (k >= ACT0 && k < ACT0 + NACT) begin
            e.pix = (int'(v) > blk) ? DW'(int'(v) - blk) : '0;
            e.sol = (k == ACT0);
            e.eol = (k == ACT0 + NACT - 1);
            q.push_back(e);
         end
         send(v);
      end
      repeat (4) @(negedge clk);
      if (n == LINE_N) begin
         checks++;
         if (n_out != NACT || q.size() != 0) begin
            errors++;
            $display("FAIL R2 line count: got %0d, expected %0d", n_out, NACT);
         end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || out_sol !== 1'b0 || out_eol !== 1'b0 || overrun !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: got v=%0b s=%0b e=%0b o=%0b, expected 0", out_valid, out_sol,
                  out_eol, overrun);
      end
      rst = 1'b0;
      run_line(0, LINE_N, 1'b0);           // R3 R4 first line after reset
      run_line(1, LINE_N, 1'b0);           // R3 new black level per line
      // R8: strobes outside a line are ignored
      n_out = 0;
      for (int i = 0; i < 8; i++) send(DW'(1234 + i));
      repeat (4) @(negedge clk);
      checks++;
      if (n_out != 0) begin
         errors++;
         $display("FAIL R8 idle strobes: got %0d outputs, expected 0", n_out);
      end
      run_line(3, 60, 1'b0);               // aborted line
      run_line(2, LINE_N, 1'b1);           // R7 restart after abort, saturation R4
      run_line(1, 0, 1'b0);                // line start with no samples
      run_line(0, LINE_N, 1'b1);           // R7 back-to-back starts
      run_line(3, LINE_N, 1'b0);           // R7 after complete line
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2 leftover: got %0d pending, expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule